// File: doc/BRIEF.md
# Tick-Framed Serial Output Shifter

The block turns one processed data word per bunch-crossing tick into a serial bit stream. It runs on a fast clock at eight times the tick rate. A one-cycle tick strobe marks the single fast-clock edge in each tick where tick-rate state may change. A live-crossing flag is sampled on that edge and then held back by one more full tick. Only after that delay does it steer a word multiplexer, which chooses the filtered data word when the flag is set and an all-zero word when it is clear.

On every tick edge the chosen word is loaded in parallel into a shift register. Its bits then leave least significant first, one per fast cycle. The block forms a parity bit for the frame together with a partner shifter. Its own word parity is XORed with the partner's parity input one cycle after the load, and that joint bit is driven on a parity output. The same joint bit also fills the last slot of the serial frame. A final output register adds one fast cycle of latency. With the default 7-bit word, a frame is exactly eight slots long and fills one tick.

Top module: `tick_serial_shifter`

## Requirements
- R1: While `rst_n` is low, `ser_o` and `par_o` are 0. Reset also clears the live-flag pipeline and leaves the shifter idle.
- R2: A `live_i` value sampled on tick edge k controls the word loaded on tick edge k+2. After reset, the first two loads are therefore all-zero words.
- R3: When the delayed live flag is 0, the word loaded is all zeros, whatever `filt_i` holds.
- R4: On each tick edge (`tick_en_i`=1), the word is loaded in parallel. Bit j of the loaded word appears on `ser_o` after the (j+2)-th rising edge counted from the load edge, for j from 0 to DATA_W-1. The load edge itself counts as the first, so bit 0 appears one edge after the load edge. This is LSB first.
- R5: On the edge that follows the load edge, `par_o` takes the XOR of all bits of the loaded word XOR `par_i`. `par_o` then holds that value until the next such edge.
- R6: Serial slot DATA_W carries the joint parity bit. It appears on `ser_o` after the (DATA_W+2)-th edge counted from the load edge, with the load edge as the first.
- R7: `live_i`, `filt_i` and `par_i` are sampled only on the edges named in R2, R4 and R5. Changes at other times have no effect.
- R8: If no tick edge follows the parity slot, `ser_o` stays 0 until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, eight periods per tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | One-cycle strobe marking the tick edge |
| live_i | input | 1 | Live-crossing flag, sampled on tick edges |
| filt_i | input | DATA_W | Filtered data word |
| par_i | input | 1 | Parity from the partner shifter |
| ser_o | output | 1 | Registered serial output, LSB first, then parity |
| par_o | output | 1 | Joint parity driven to the partner |

## Verification
The bench flips `live_i`, `filt_i` and `par_i` right after each point where they are sampled. A design that sampled them at the wrong time, or on every edge, would corrupt later frames. It checks that a live flag takes effect two tick edges later and not one. A missing delay stage would serialize the filtered word one tick early, and an extra stage would zero it. Ticks with gaps between them test whether the frame stops cleanly after the parity slot, rather than shifting stale bits or repeating parity. A reset taken in the middle of a run must flush the live pipeline, so that the first two frames afterwards are all zeros.

// File: rtl/sos_pkg.sv
package sos_pkg;
  localparam int unsigned MAX_W = 64;

  typedef enum logic [1:0] {
    SLOT_DATA = 2'd0,
    SLOT_PAR  = 2'd1,
    SLOT_IDLE = 2'd2
  } slot_kind_e;

  // even-count XOR reduction of a zero-extended word
  function automatic logic word_parity(input logic [MAX_W-1:0] v);
    logic p;
    p = 1'b0;
    for (int i = 0; i < MAX_W; i++) p = p ^ v[i];
    return p;
  endfunction

  // what a given slot index of the frame carries
  function automatic slot_kind_e slot_kind(input int unsigned idx, input int unsigned dw);
    if (idx < dw) return SLOT_DATA;
    else if (idx == dw) return SLOT_PAR;
    else return SLOT_IDLE;
  endfunction
endpackage

// File: rtl/sos_live_pipe.sv
module sos_live_pipe #(
  parameter int unsigned DELAY_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en_i,
  input  logic live_i,
  output logic cap_o,
  output logic sel_o
);
  localparam int unsigned STAGES = DELAY_TICKS + 1;

  logic [STAGES-1:0] stage_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= 1'b0;
          else if (tick_en_i) stage_q[0] <= live_i;
        end
      end else begin : g_dly
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[g] <= 1'b0;
          else if (tick_en_i) stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign cap_o = stage_q[0];
  assign sel_o = stage_q[STAGES-1];
endmodule

// File: rtl/sos_word_mux.sv
module sos_word_mux #(
  parameter int unsigned DATA_W = 7
) (
  input  logic              live_sel_i,
  input  logic [DATA_W-1:0] filt_i,
  output logic [DATA_W-1:0] word_o
);
  always_comb begin
    if (live_sel_i) word_o = filt_i;
    else            word_o = '0;
  end
endmodule

// File: rtl/sos_shifter.sv
module sos_shifter #(
  parameter int unsigned DATA_W = 7,
  localparam int unsigned CW = $clog2(DATA_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] word_i,
  input  logic              joint_par_i,
  output logic              ser_next_o,
  output logic              lpar_o,
  output logic [CW-1:0]     slot_o
);
  localparam int unsigned PW = sos_pkg::MAX_W;
  localparam logic [CW-1:0] IDLE_SLOT = CW'(DATA_W + 1);

  logic [DATA_W-1:0] sh_q;
  logic [CW-1:0]     slot_q;
  logic              lpar_q;
  sos_pkg::slot_kind_e kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      slot_q <= IDLE_SLOT;
      lpar_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= word_i;
      slot_q <= '0;
      lpar_q <= sos_pkg::word_parity(PW'(word_i));
    end else if (slot_q != IDLE_SLOT) begin
      slot_q <= slot_q + 1'b1;
      sh_q   <= {1'b0, sh_q[DATA_W-1:1]};
    end
  end

  always_comb begin
    kind = sos_pkg::slot_kind(32'(slot_q), DATA_W);
    case (kind)
      sos_pkg::SLOT_DATA: ser_next_o = sh_q[0];
      sos_pkg::SLOT_PAR:  ser_next_o = joint_par_i;
      default:            ser_next_o = 1'b0;
    endcase
  end

  assign lpar_o = lpar_q;
  assign slot_o = slot_q;
endmodule

// File: rtl/sos_par_join.sv
module sos_par_join #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] slot_i,
  input  logic          lpar_i,
  input  logic          par_i,
  output logic          par_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_o <= 1'b0;
    else if (slot_i == '0) par_o <= lpar_i ^ par_i;
  end
endmodule

// File: rtl/tick_serial_shifter.sv
module tick_serial_shifter #(
  parameter int unsigned DATA_W      = 7,
  parameter int unsigned DELAY_TICKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en_i,
  input  logic              live_i,
  input  logic [DATA_W-1:0] filt_i,
  input  logic              par_i,
  output logic              ser_o,
  output logic              par_o
);
  localparam int unsigned CW = $clog2(DATA_W + 2);

  // named internal events for the checker
  logic              tick_load;
  logic              live_cap;
  logic              live_sel;
  logic [DATA_W-1:0] word_sel;
  logic              ser_next;
  logic              lpar;
  logic [CW-1:0]     slot_idx;

  assign tick_load = tick_en_i;

  sos_live_pipe #(.DELAY_TICKS(DELAY_TICKS)) u_live (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_load), .live_i(live_i),
    .cap_o(live_cap), .sel_o(live_sel)
  );

  sos_word_mux #(.DATA_W(DATA_W)) u_mux (
    .live_sel_i(live_sel), .filt_i(filt_i), .word_o(word_sel)
  );

  sos_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(tick_load), .word_i(word_sel),
    .joint_par_i(par_o), .ser_next_o(ser_next), .lpar_o(lpar), .slot_o(slot_idx)
  );

  sos_par_join #(.CW(CW)) u_pj (
    .clk(clk), .rst_n(rst_n), .slot_i(slot_idx), .lpar_i(lpar),
    .par_i(par_i), .par_o(par_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ser_o <= 1'b0;
    else        ser_o <= ser_next;
  end
endmodule

// File: rtl/sos_chk.sv
module sos_chk #(
  parameter int unsigned DATA_W = 7,
  parameter int unsigned CW     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en_i,
  input logic              live_i,
  input logic              par_i,
  input logic              live_cap,
  input logic              live_sel,
  input logic [DATA_W-1:0] word_sel,
  input logic [CW-1:0]     slot_idx,
  input logic              ser_o,
  input logic              par_o
);
  localparam logic [CW-1:0] PAR_SLOT  = CW'(DATA_W);
  localparam logic [CW-1:0] IDLE_SLOT = CW'(DATA_W + 1);

  assert_reset_zero_R1: assert property (@(negedge clk)
    !rst_n |-> (ser_o == 1'b0 && par_o == 1'b0));

  assert_live_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en_i |=> live_cap == $past(live_i));

  assert_live_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en_i |=> live_sel == $past(live_cap));

  assert_zero_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en_i && !live_sel) |=> ##1 ser_o == 1'b0);

  assert_lsb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en_i |=> ##1 ser_o == $past(word_sel[0], 2));

  assert_par_join_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en_i |=> ##1 par_o == ((^$past(word_sel, 2)) ^ $past(par_i)));

  assert_par_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx == PAR_SLOT && !tick_en_i) |=> ser_o == $past(par_o));

  assert_live_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en_i |=> ($stable(live_cap) && $stable(live_sel)));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_idx == IDLE_SLOT) |=> ser_o == 1'b0);
endmodule

bind tick_serial_shifter sos_chk #(.DATA_W(DATA_W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i), .live_i(live_i),
  .par_i(par_i), .live_cap(live_cap), .live_sel(live_sel),
  .word_sel(word_sel), .slot_idx(slot_idx), .ser_o(ser_o), .par_o(par_o)
);

// File: tb/sim_tick_serial_shifter.sv
module sim_tick_serial_shifter;
  localparam int DW = 7;
  localparam int NV = 12;
  // vector: {gap[1:0], live, par, word[6:0]}
  typedef logic [10:0] vec_t;
  localparam vec_t VEC [NV] = '{
    {2'd0, 1'b1, 1'b0, 7'h35}, {2'd0, 1'b1, 1'b1, 7'h0A},
    {2'd0, 1'b0, 1'b0, 7'h7F}, {2'd0, 1'b1, 1'b0, 7'h01},
    {2'd2, 1'b0, 1'b1, 7'h40}, {2'd0, 1'b1, 1'b0, 7'h55},
    {2'd1, 1'b1, 1'b1, 7'h2A}, {2'd0, 1'b1, 1'b0, 7'h66},
    {2'd3, 1'b0, 1'b1, 7'h13}, {2'd0, 1'b0, 1'b0, 7'h7E},
    {2'd0, 1'b1, 1'b1, 7'h00}, {2'd2, 1'b0, 1'b0, 7'h49}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_en = 1'b0;
  logic live_i = 1'b0;
  logic par_i = 1'b0;
  logic [DW-1:0] filt = '0;
  logic ser_o, par_o;

  int checks = 0;
  int fails = 0;
  logic h1 = 1'b0, h2 = 1'b0, prev_par = 1'b0;

  always #4 clk = ~clk;

  tick_serial_shifter #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .live_i(live_i),
    .filt_i(filt), .par_i(par_i), .ser_o(ser_o), .par_o(par_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b1; live_i = 1'b1; filt = '1;
    repeat (3) @(negedge clk);
    check("R1 ser_o in reset", ser_o, 1'b0);
    check("R1 par_o in reset", par_o, 1'b0);
    tick_en = 1'b0; live_i = 1'b0; filt = '0;
    rst_n = 1'b1;
    h1 = 1'b0; h2 = 1'b0; prev_par = 1'b0;
    @(negedge clk);
  endtask

  // starts and ends at a negedge
  task automatic do_tick(input logic live, input logic par, input logic [DW-1:0] word,
                         input int gap);
    logic [DW-1:0] eff;
    logic ep;
    string tag;
    eff = h2 ? word : '0;
    tag = h2 ? "R4 LSB-first bit (R7 flips ignored)" :
          ((h1 || live) ? "R2 live not yet through delay" : "R3 zero word (R7 flips ignored)");
    ep = (^eff) ^ par;
    h2 = h1; h1 = live;
    tick_en = 1'b1; live_i = live; filt = word; par_i = par;
    for (int s = 0; s < DW + 1; s++) begin
      @(posedge clk); @(negedge clk);
      if (s == 0) begin
        tick_en = 1'b0; live_i = ~live; filt = ~word;
        check("R6 previous frame parity slot", ser_o, prev_par);
      end else begin
        check(tag, ser_o, eff[s-1]);
        check("R5 joint parity output", par_o, ep);
        if (s == 1) par_i = ~par;
      end
    end
    prev_par = ep;
    for (int g = 0; g < gap; g++) begin
      @(posedge clk); @(negedge clk);
      if (g == 0) check("R6 parity slot before gap", ser_o, ep);
      else        check("R8 idle after frame", ser_o, 1'b0);
      live_i = ~live_i; filt = filt ^ 7'h2B;
    end
    if (gap != 0) prev_par = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    do_reset();
    check("R1 idle output after reset", ser_o, 1'b0);
    for (int i = 0; i < NV; i++) begin
      do_tick(VEC[i][8], VEC[i][7], VEC[i][6:0], int'(VEC[i][10:9]));
    end
    // reset in the middle of activity flushes the live pipeline (R2)
    do_reset();
    do_tick(1'b1, 1'b0, 7'h5A, 0);
    do_tick(1'b1, 1'b1, 7'h5A, 0);
    do_tick(1'b1, 1'b0, 7'h5A, 0);
    do_tick(1'b0, 1'b1, 7'h33, 3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule